// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing and Programmable Thresholds

This block is a first-in first-out buffer with separate write and read clocks. By default it holds 1024 words of 36 bits. Data goes in on the write clock and comes out in order on the read clock. The two clocks run freely and may be unrelated or the same clock. Pointers cross between the two domains as Gray codes through two-flop synchronizers. The write domain works out the full condition and the read domain works out the empty condition.

The output timing is chosen at master reset.

- **Standard timing:** the read flag reports empty and the write flag reports full. A read request is needed before a word appears on the output.
- **Fall-through timing:** the read flag reports output-ready and the write flag reports input-ready. The oldest word moves to the output register by itself.

Two threshold flags give early warning, one near empty and one near full. Each offset comes from one of three presets, or from a programming step run after master reset. That step loads the offsets either bit by bit on a serial pin or as two words on the write data bus. A partial reset empties the buffer but keeps the timing mode and both offsets. A master reset reloads everything.

Top module: `dcfifo_top`

## Requirements
- R1: After master reset the buffer is empty and both threshold flags read as for level 0. In standard mode `rd_flag`=1 and `wr_flag`=0. In fall-through mode `rd_flag`=0 and `wr_flag`=1.
- R2: The timing mode (`cfg_fwft`: 1 = fall-through), the offset source (`cfg_sel`) and the programming path (`cfg_serial`) are sampled on write-clock edges while `mrst_n` is low. The last sampled values hold until the next master reset. Later changes on these pins have no effect.
- R3: In standard mode a read accepted at a read-clock edge (`rd_en`=1 and not empty) places the oldest word on `rd_data` at that edge. Words leave in the order they were written.
- R4: In fall-through mode the oldest word appears on `rd_data` with `rd_flag`=1 without any read request. A read while `rd_flag`=1 consumes that word. `rd_flag` falls only after the last word is consumed. A read while `rd_flag`=0 is ignored. Capacity is DEPTH+1 words (RAM plus output register).
- R5: In standard mode `wr_flag`=1 once DEPTH words are stored. A write while full is ignored and leaves the stored data unchanged.
- R6: In standard mode a read while empty is ignored: `rd_data` keeps its value and no word is lost.
- R7: `cfg_sel` = 1, 2 or 3 selects preset offsets of 8, 16 or 64 respectively for both thresholds. `cfg_sel`=0 selects programming.
- R8: `almost_empty`=1 exactly when the stored level is at or below the empty offset. `almost_full`=1 exactly when DEPTH minus the level is at or below the full offset.
- R9: With `cfg_sel`=0 and `cfg_serial`=0, the first two writes after master reset are consumed as offsets. The empty offset comes first and the full offset second, each taken from `wr_data[OFS_W-1:0]`. Neither word is stored.
- R10: With `cfg_sel`=0 and `cfg_serial`=1, 2·OFS_W bits are shifted in on `ser_di` on write-clock edges where `ser_en`=1. The empty offset goes first, then the full offset, each MSB first. Until that completes, writes are blocked and `wr_flag` shows not-ready (1 in standard mode).
- R11: A partial reset (`prst_n` low) empties the buffer but keeps the timing mode and both offsets.
- R12: A write and a read on the same clock edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| cfg_fwft | input | 1 | Timing mode select, sampled during master reset |
| cfg_sel | input | 2 | Offset source: 0 program, 1/2/3 presets 8/16/64 |
| cfg_serial | input | 1 | Programming path: 1 serial, 0 parallel |
| ser_en | input | 1 | Serial programming enable |
| ser_di | input | 1 | Serial programming data |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read data |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_full | output | 1 | Free space at or below the full offset |
| almost_empty | output | 1 | Level at or below the empty offset |

## Verification
The assertions assume that the configuration pins hold steady for the whole master reset. They also assume that serial programming is not pulsed while a partial reset is low. The checks on pointer stability assume that both resets release away from the clock edges. The bench drives one 50 MHz clock into both ports, changes every input on the falling edge, and lets at least five edges pass before it reads a flag that depends on a synchronizer. This keeps flag checks away from pointer values still in flight between domains.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    typedef enum logic {
        TM_STD  = 1'b0,
        TM_FWFT = 1'b1
    } tmode_e;

    // Preset threshold chosen by the offset-source code
    function automatic logic [15:0] preset_ofs(input logic [1:0] sel);
        case (sel)
            2'd1:    return 16'd8;
            2'd2:    return 16'd16;
            2'd3:    return 16'd64;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/dcfifo_cfg.sv
module dcfifo_cfg
    import dcfifo_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             wclk,
    input  logic             mrst_n,
    input  logic             cfg_fwft,
    input  logic [1:0]       cfg_sel,
    input  logic             cfg_serial,
    input  logic             ser_en,
    input  logic             ser_di,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_ofs,
    output tmode_e           mode,
    output logic             busy,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam int CNT_W = $clog2(2 * OFS_W) + 1;

    typedef struct packed {
        tmode_e             mode;
        logic               serial;
        logic               busy;
        logic [OFS_W-1:0]   ae;
        logic [OFS_W-1:0]   af;
        logic [CNT_W-1:0]   cnt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!mrst_n) begin
            cfg_d.mode   = cfg_fwft ? TM_FWFT : TM_STD;
            cfg_d.serial = cfg_serial;
            cfg_d.busy   = (cfg_sel == 2'd0);
            cfg_d.ae     = OFS_W'(preset_ofs(cfg_sel));
            cfg_d.af     = OFS_W'(preset_ofs(cfg_sel));
            cfg_d.cnt    = '0;
        end else if (cfg_q.busy) begin
            if (cfg_q.serial) begin
                if (ser_en) begin
                    {cfg_d.ae, cfg_d.af} = {cfg_q.ae[OFS_W-2:0], cfg_q.af, ser_di};
                    cfg_d.cnt = cfg_q.cnt + CNT_W'(1);
                    if (cfg_q.cnt == CNT_W'(2 * OFS_W - 1))
                        cfg_d.busy = 1'b0;
                end
            end else if (wr_en) begin
                if (cfg_q.cnt == '0) begin
                    cfg_d.ae = wr_ofs;
                end else begin
                    cfg_d.af   = wr_ofs;
                    cfg_d.busy = 1'b0;
                end
                cfg_d.cnt = cfg_q.cnt + CNT_W'(1);
            end
        end
    end

    // Configuration is loaded synchronously while master reset is held
    always_ff @(posedge wclk) begin
        cfg_q <= cfg_d;
    end

    assign mode   = cfg_q.mode;
    assign busy   = cfg_q.busy;
    assign ae_ofs = cfg_q.ae;
    assign af_ofs = cfg_q.af;

endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr #(
    parameter int DEPTH = 1024,
    parameter int OFS_W = 11
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             blocked,
    input  logic [$clog2(DEPTH):0]   rgray_in,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             we,
    output logic [$clog2(DEPTH)-1:0] waddr,
    output logic [$clog2(DEPTH):0]   wgray,
    output logic [$clog2(DEPTH):0]   wbin,
    output logic             full,
    output logic             almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int CW = (PW > OFS_W) ? PW : OFS_W;

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic [AW:0] s1;
        logic [AW:0] s2;
    } wr_t;

    wr_t wr_d, wr_q;
    logic [AW:0] rbin_s, level, free;
    logic        full_c, we_c;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wr_d    = wr_q;
        full_c  = (wr_q.gray == {~wr_q.s2[AW:AW-1], wr_q.s2[AW-2:0]});
        we_c    = wr_en && !full_c && !blocked;
        wr_d.s1 = rgray_in;
        wr_d.s2 = wr_q.s1;
        if (we_c) begin
            wr_d.bin  = wr_q.bin + PW'(1);
            wr_d.gray = (wr_d.bin >> 1) ^ wr_d.bin;
        end
        rbin_s = g2b(wr_q.s2);
        level  = wr_q.bin - rbin_s;
        free   = PW'(DEPTH) - level;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign we          = we_c;
    assign waddr       = wr_q.bin[AW-1:0];
    assign wgray       = wr_q.gray;
    assign wbin        = wr_q.bin;
    assign full        = full_c;
    assign almost_full = (CW'(free) <= CW'(af_ofs));

endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 36,
    parameter int OFS_W = 11
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  tmode_e           mode,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [$clog2(DEPTH):0]   wgray_in,
    input  logic [DW-1:0]    mem_rdata,
    output logic [$clog2(DEPTH)-1:0] raddr,
    output logic [$clog2(DEPTH):0]   rgray,
    output logic [$clog2(DEPTH):0]   rbin,
    output logic             ram_empty,
    output logic [DW-1:0]    rd_data,
    output logic             rd_flag,
    output logic             almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int CW = (PW > OFS_W) ? PW : OFS_W;

    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic [AW:0]   s1;
        logic [AW:0]   s2;
        logic [DW-1:0] dout;
        logic          ovalid;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [AW:0] wbin_s, level;
    logic        empty_c, pop;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rd_d    = rd_q;
        empty_c = (rd_q.gray == rd_q.s2);
        rd_d.s1 = wgray_in;
        rd_d.s2 = rd_q.s1;
        if (mode == TM_FWFT) pop = !empty_c && (!rd_q.ovalid || rd_en);
        else                 pop = !empty_c && rd_en;
        if (pop) begin
            rd_d.bin  = rd_q.bin + PW'(1);
            rd_d.gray = (rd_d.bin >> 1) ^ rd_d.bin;
            rd_d.dout = mem_rdata;
            if (mode == TM_FWFT) rd_d.ovalid = 1'b1;
        end else if (mode == TM_FWFT && rd_en && rd_q.ovalid) begin
            rd_d.ovalid = 1'b0;
        end
        wbin_s = g2b(rd_q.s2);
        level  = wbin_s - rd_q.bin + PW'(rd_q.ovalid);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign raddr        = rd_q.bin[AW-1:0];
    assign rgray        = rd_q.gray;
    assign rbin         = rd_q.bin;
    assign ram_empty    = empty_c;
    assign rd_data      = rd_q.dout;
    assign rd_flag      = (mode == TM_FWFT) ? rd_q.ovalid : empty_c;
    assign almost_empty = (CW'(level) <= CW'(ae_ofs));

endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 36
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic [1:0]    cfg_sel,
    input  logic          cfg_serial,
    input  logic          ser_en,
    input  logic          ser_di,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          wr_flag,
    output logic          rd_flag,
    output logic          almost_full,
    output logic          almost_empty
);
    localparam int AW    = $clog2(DEPTH);
    localparam int OFS_W = (AW + 1 > 7) ? AW + 1 : 7;

    logic             data_rst_n;
    tmode_e           mode;
    logic             busy, we, full_w, ram_empty;
    logic [OFS_W-1:0] ae_ofs, af_ofs;
    logic [AW-1:0]    waddr, raddr;
    logic [AW:0]      wgray, wbin, rgray, rbin;
    logic [DW-1:0]    mem [DEPTH];
    logic [DW-1:0]    mem_rdata;

    assign data_rst_n = mrst_n && prst_n;

    dcfifo_cfg #(.OFS_W(OFS_W)) u_cfg (
        .wclk(wclk), .mrst_n(mrst_n), .cfg_fwft(cfg_fwft), .cfg_sel(cfg_sel),
        .cfg_serial(cfg_serial), .ser_en(ser_en), .ser_di(ser_di),
        .wr_en(wr_en), .wr_ofs(wr_data[OFS_W-1:0]),
        .mode(mode), .busy(busy), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcfifo_wr #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_wr (
        .wclk(wclk), .rst_n(data_rst_n), .wr_en(wr_en), .blocked(busy),
        .rgray_in(rgray), .af_ofs(af_ofs), .we(we), .waddr(waddr),
        .wgray(wgray), .wbin(wbin), .full(full_w), .almost_full(almost_full)
    );

    dcfifo_rd #(.DEPTH(DEPTH), .DW(DW), .OFS_W(OFS_W)) u_rd (
        .rclk(rclk), .rst_n(data_rst_n), .rd_en(rd_en), .mode(mode),
        .ae_ofs(ae_ofs), .wgray_in(wgray), .mem_rdata(mem_rdata),
        .raddr(raddr), .rgray(rgray), .rbin(rbin), .ram_empty(ram_empty),
        .rd_data(rd_data), .rd_flag(rd_flag), .almost_empty(almost_empty)
    );

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wr_data;
    end

    assign mem_rdata = mem[raddr];
    assign wr_flag   = (mode == TM_FWFT) ? !(full_w || busy) : (full_w || busy);

endmodule

// File: rtl/dcfifo_top_chk.sv
module dcfifo_top_chk
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 36,
    parameter int OFS_W = 11
) (
    input logic                 wclk,
    input logic                 rclk,
    input logic                 mrst_n,
    input logic                 prst_n,
    input logic                 data_rst_n,
    input logic                 full_w,
    input logic                 busy,
    input logic                 ram_empty,
    input logic [$clog2(DEPTH):0] wbin,
    input logic [$clog2(DEPTH):0] rbin,
    input tmode_e               mode,
    input logic                 rd_en,
    input logic                 rd_flag,
    input logic [DW-1:0]        rd_data,
    input logic [OFS_W-1:0]     ae_ofs,
    input logic [OFS_W-1:0]     af_ofs
);
    p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!data_rst_n)
        full_w |=> $stable(wbin));

    p_busy_blocks_r10: assert property (@(posedge wclk) disable iff (!data_rst_n)
        busy |=> $stable(wbin));

    p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!data_rst_n)
        ram_empty |=> $stable(rbin));

    p_ready_holds_r4: assert property (@(posedge rclk) disable iff (!data_rst_n)
        (mode == TM_FWFT && rd_flag && !rd_en) |=> (rd_flag && $stable(rd_data)));

    p_cfg_kept_r11: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!prst_n && !busy) |=> ($stable(mode) && $stable(ae_ofs) && $stable(af_ofs)));

endmodule

bind dcfifo_top dcfifo_top_chk #(.DEPTH(DEPTH), .DW(DW), .OFS_W(OFS_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .data_rst_n(data_rst_n), .full_w(full_w), .busy(busy),
    .ram_empty(ram_empty), .wbin(wbin), .rbin(rbin), .mode(mode),
    .rd_en(rd_en), .rd_flag(rd_flag), .rd_data(rd_data),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/dcfifo_top_tb.sv
module dcfifo_top_tb;
    localparam int DEPTH = 128;
    localparam int DW    = 36;

    logic clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1;
    logic cfg_fwft = 1'b0, cfg_serial = 1'b0, ser_en = 1'b0, ser_di = 1'b0;
    logic [1:0] cfg_sel = 2'd1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic wr_flag, rd_flag, almost_full, almost_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dcfifo_top #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_fwft(cfg_fwft), .cfg_sel(cfg_sel), .cfg_serial(cfg_serial),
        .ser_en(ser_en), .ser_di(ser_di), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .wr_flag(wr_flag), .rd_flag(rd_flag),
        .almost_full(almost_full), .almost_empty(almost_empty)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic mreset(input bit fwft, input logic [1:0] sel, input bit ser);
        @(negedge clk);
        mrst_n = 1'b0; cfg_fwft = fwft; cfg_sel = sel; cfg_serial = ser;
        repeat (3) @(negedge clk);
        mrst_n = 1'b1;
        settle();
    endtask

    task automatic preset_pulse();
        @(negedge clk); prst_n = 1'b0;
        repeat (2) @(negedge clk); prst_n = 1'b1;
        settle();
    endtask

    task automatic push(input logic [DW-1:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Standard mode: fill to full and drain, checking thresholds at every level
    task automatic sweep(input int aeo, input int afo, input int base);
        logic [DW-1:0] hold;
        check(almost_empty == 1'b1, "R8 level0 ae", DW'(almost_empty), 1);
        for (int n = 1; n <= DEPTH; n++) begin
            push(DW'(base + n));
            settle();
            check(almost_empty == (n <= aeo), "R8 fill ae", DW'(almost_empty), DW'(n <= aeo));
            check(almost_full == ((DEPTH - n) <= afo), "R8 fill af",
                  DW'(almost_full), DW'((DEPTH - n) <= afo));
        end
        check(wr_flag == 1'b1, "R5 full flag", DW'(wr_flag), 1);
        push(DW'(36'h0BAD));
        settle();
        for (int k = 1; k <= DEPTH; k++) begin
            pop();
            check(rd_data == DW'(base + k), "R3/R5 data order", rd_data, DW'(base + k));
            settle();
            check(almost_empty == ((DEPTH - k) <= aeo), "R8 drain ae",
                  DW'(almost_empty), DW'((DEPTH - k) <= aeo));
            check(almost_full == (k <= afo), "R8 drain af", DW'(almost_full), DW'(k <= afo));
        end
        check(rd_flag == 1'b1, "R5 empty after drain", DW'(rd_flag), 1);
        hold = rd_data;
        pop();
        settle();
        check(rd_data == hold, "R6 read on empty", rd_data, hold);
        check(rd_flag == 1'b1, "R6 still empty", DW'(rd_flag), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] q[$];
        logic [15:0] bits;
        int cnt;

        // R1 standard reset state, preset 8 (R7)
        mreset(1'b0, 2'd1, 1'b0);
        check(rd_flag == 1'b1, "R1 std empty", DW'(rd_flag), 1);
        check(wr_flag == 1'b0, "R1 std not full", DW'(wr_flag), 0);
        check(almost_full == 1'b0, "R1 af", DW'(almost_full), 0);
        sweep(8, 8, 1000);

        // R12 simultaneous write and read
        for (int i = 0; i < 3; i++) begin push(DW'(500 + i)); q.push_back(DW'(500 + i)); end
        settle();
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_data = DW'(600 + i); rd_en = 1'b1;
            q.push_back(DW'(600 + i));
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            check(rd_data == q[0], "R12 same-edge read", rd_data, q[0]);
            void'(q.pop_front());
        end
        settle();
        while (q.size() > 0) begin
            pop();
            check(rd_data == q[0], "R12 same-edge write kept", rd_data, q[0]);
            void'(q.pop_front());
        end
        settle();
        check(rd_flag == 1'b1, "R12 drained", DW'(rd_flag), 1);

        // R7 other presets
        mreset(1'b0, 2'd2, 1'b0);
        sweep(16, 16, 2000);
        mreset(1'b0, 2'd3, 1'b0);
        sweep(64, 64, 3000);

        // R9 parallel programming: empty offset 5, full offset 100
        mreset(1'b0, 2'd0, 1'b0);
        check(wr_flag == 1'b1, "R9 blocked before program", DW'(wr_flag), 1);
        push(DW'(5));
        push(DW'(100));
        settle();
        check(wr_flag == 1'b0, "R9 ready after program", DW'(wr_flag), 0);
        check(rd_flag == 1'b1, "R9 offset words not stored", DW'(rd_flag), 1);
        sweep(5, 100, 4000);

        // R10 serial programming: empty offset 3, full offset 120, MSB first
        mreset(1'b0, 2'd0, 1'b1);
        bits = {8'd3, 8'd120};
        push(DW'(77));
        settle();
        check(wr_flag == 1'b1, "R10 not ready while busy", DW'(wr_flag), 1);
        check(rd_flag == 1'b1, "R10 write blocked", DW'(rd_flag), 1);
        for (int b = 15; b >= 0; b--) begin
            ser_en = 1'b1; ser_di = bits[b];
            @(negedge clk);
        end
        ser_en = 1'b0;
        settle();
        check(wr_flag == 1'b0, "R10 ready after shift", DW'(wr_flag), 0);
        sweep(3, 120, 5000);

        // R11 partial reset keeps offsets
        for (int i = 0; i < 10; i++) push(DW'(i));
        preset_pulse();
        check(rd_flag == 1'b1, "R11 data cleared", DW'(rd_flag), 1);
        check(almost_empty == 1'b1, "R11 level zero", DW'(almost_empty), 1);
        sweep(3, 120, 6000);

        // R4 fall-through, R2 mode latched
        mreset(1'b1, 2'd1, 1'b0);
        check(rd_flag == 1'b0, "R1 fwft not ready", DW'(rd_flag), 0);
        check(wr_flag == 1'b1, "R1 fwft input ready", DW'(wr_flag), 1);
        cfg_fwft = 1'b0;
        pop();
        push(DW'(36'hA1));
        settle();
        check(rd_flag == 1'b1, "R2/R4 word falls through", DW'(rd_flag), 1);
        check(rd_data == DW'(36'hA1), "R4 first word", rd_data, DW'(36'hA1));
        push(DW'(36'hB2)); push(DW'(36'hC3));
        settle();
        check(rd_data == DW'(36'hA1), "R4 held without read", rd_data, DW'(36'hA1));
        pop();
        check(rd_data == DW'(36'hB2) && rd_flag, "R4 second word", rd_data, DW'(36'hB2));
        pop();
        check(rd_data == DW'(36'hC3) && rd_flag, "R4 third word", rd_data, DW'(36'hC3));
        pop();
        settle();
        check(rd_flag == 1'b0, "R4 ready falls after last", DW'(rd_flag), 0);
        pop();
        push(DW'(36'hD4));
        settle();
        check(rd_data == DW'(36'hD4) && rd_flag, "R4 read while not ready ignored",
              rd_data, DW'(36'hD4));
        pop();
        settle();
        cnt = 0;
        while (wr_flag && cnt < DEPTH + 10) begin
            push(DW'(7000 + cnt));
            cnt++;
            settle();
        end
        check(cnt == DEPTH + 1, "R4 fwft capacity", DW'(cnt), DW'(DEPTH + 1));
        for (int k = 0; k < DEPTH + 1; k++) begin
            check(rd_data == DW'(7000 + k), "R4 fwft order", rd_data, DW'(7000 + k));
            pop();
        end
        settle();
        check(rd_flag == 1'b0, "R4 fwft drained", DW'(rd_flag), 0);

        // R11 partial reset keeps fall-through mode
        push(DW'(36'hE5));
        preset_pulse();
        check(rd_flag == 1'b0, "R11 fwft cleared", DW'(rd_flag), 0);
        check(wr_flag == 1'b1, "R11 fwft mode kept", DW'(wr_flag), 1);
        push(DW'(36'hF6));
        settle();
        check(rd_data == DW'(36'hF6) && rd_flag, "R11 fwft after partial", rd_data, DW'(36'hF6));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule